// File: doc/BRIEF.md
# Nap/Doze Snoop Power Controller

This block is the power-mode sequencer on the processor side of a coherent bus. A core request moves it from full power into nap, where it consumes little and cannot snoop, or into sleep, where only thermal and monitoring logic remain alive. While napping, the system keeps the quiesce-acknowledge line high. Dropping that line for a run of consecutive bus cycles wakes the snoop path, and the controller drops into doze. Once the line is raised again and every snoop accepted in doze is finished, it falls back into nap without help from the core. A snoop is finished a short time after its address phase, or, when it needs a push, a short time after the push data phase ends.

Any wake source (external, system-management or machine-check interrupt, decrementer, performance-monitor or thermal interrupt, soft reset) brings the controller from nap, doze or sleep into a wake phase of fixed length, and then into full power. Hard reset is asynchronous and forces full power at once. In sleep the controller can also ask for the clock generator to be switched off, but only when the clock configuration input allows it.

Top module: `snoop_power_ctrl`

## Requirements
- R1: Hard reset (`rstHardN` low) forces the outputs at once, with no clock edge: mode FULL, `snoopEn` 1, `pllOffReq` 0, `protoErr` 0. The mode codes are FULL=0, DOZE=1, NAP=2, SLEEP=3, WAKING=4.
- R2: In FULL, a high `sleepReq` at a clock edge moves to SLEEP. Otherwise a high `napReq` moves to NAP. When both are high, SLEEP wins.
- R3: In NAP, the edge that samples `quiesceAck` low for the fourth consecutive time moves to DOZE. Any sample of `quiesceAck` high restarts the run from zero.
- R4: A `xferStart` sampled in NAP is not snooped. `protoErr` goes high for exactly the following cycle and the mode stays NAP. A later return from doze is not delayed by it.
- R5: A `xferStart` sampled in DOZE with `pushNeeded` low at edge T returns the block to NAP at the first edge at or after T+3 that samples `quiesceAck` high. Until then it stays in DOZE.
- R6: A `xferStart` sampled in DOZE with `pushNeeded` high holds DOZE until `pushDataDone` is sampled at edge D. The block then returns to NAP at the first edge at or after D+3 that samples `quiesceAck` high.
- R7: In DOZE with no snoop outstanding, an edge that samples `quiesceAck` high returns to NAP.
- R8: A high bit anywhere in `wakeSrc` at an edge in NAP, DOZE or SLEEP moves to WAKING. The mode becomes FULL on the third edge after that one.
- R9: `snoopEn` is 1 exactly when the mode is FULL or DOZE.
- R10: `pllOffReq` is 1 exactly when the mode is SLEEP and `pllCfgOff` is 1.
- R11: `napReq` and `sleepReq` have no effect outside FULL, and `wakeSrc` has no effect in FULL. A `xferStart` in SLEEP leaves the mode unchanged and does not raise `protoErr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstHardN | input | 1 | Asynchronous hard reset, active low |
| quiesceAck | input | 1 | Quiesce acknowledge from the system; low requests snooping |
| xferStart | input | 1 | Transfer-start strobe of a snooped address phase |
| pushNeeded | input | 1 | Qualifies `xferStart`: the snoop needs a data push |
| pushDataDone | input | 1 | Strobe marking the end of the push data phase |
| wakeSrc | input | 7 | Synchronous wake sources, any bit high wakes |
| napReq | input | 1 | Core request to enter nap |
| sleepReq | input | 1 | Core request to enter sleep |
| pllCfgOff | input | 1 | Clock configuration allows the clock generator to be turned off |
| mode | output | 3 | Current mode code |
| snoopEn | output | 1 | Snooping is allowed |
| pllOffReq | output | 1 | Request to turn off the clock generator |
| protoErr | output | 1 | One-cycle pulse on a transfer-start seen while napping |

## Verification
The assertions assume the wake sources and core requests are sampled synchronously, and that `pushDataDone` arrives only after a push-qualified transfer start. The stimulus keeps to this: every input changes one time unit after a rising edge, and push completion is driven only while a push is outstanding. The low-acknowledge run that the checker counts uses the same synchronous sampling as the design. The bench therefore always holds the acknowledge line at a defined level.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [2:0] {
    MODE_FULL  = 3'd0,
    MODE_DOZE  = 3'd1,
    MODE_NAP   = 3'd2,
    MODE_SLEEP = 3'd3,
    MODE_WAKE  = 3'd4
  } pwrMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic countNeg;
    logic snoopAccept;
    logic snoopFlush;
    logic wakeLoad;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic negHit;
    logic snoopIdle;
    logic wakeDone;
  } dpStatus_t;

endpackage

// File: rtl/spc_dpath.sv
module spc_dpath
  import spc_pkg::*;
#(
  parameter int NEG_THRESH = 4,
  parameter int SETTLE_CYC = 2,
  parameter int WAKE_LAT   = 3
) (
  input  logic       clk,
  input  logic       rstHardN,
  input  logic       quiesceAck,
  input  logic       pushNeeded,
  input  logic       pushDataDone,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);

  localparam int NEG_W  = $clog2(NEG_THRESH + 1);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int WAKE_W = (WAKE_LAT > 2) ? $clog2(WAKE_LAT) : 1;

  localparam logic [NEG_W-1:0]  NEG_MAX  = NEG_W'(NEG_THRESH);
  localparam logic [NEG_W-1:0]  NEG_LAST = NEG_W'(NEG_THRESH - 1);
  localparam logic [SET_W-1:0]  SET_LOAD = SET_W'(SETTLE_CYC);
  localparam logic [WAKE_W-1:0] WAKE_LD  = WAKE_W'(WAKE_LAT - 1);

  logic [NEG_W-1:0]  negCnt;
  logic [SET_W-1:0]  settleCnt;
  logic [WAKE_W-1:0] wakeCnt;
  logic              pushPending;

  // consecutive negated-acknowledge counter, saturating
  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)                       negCnt <= '0;
    else if (!strobe.countNeg || quiesceAck) negCnt <= '0;
    else if (negCnt != NEG_MAX)          negCnt <= negCnt + 1'b1;
  end

  // outstanding push tracker
  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)                             pushPending <= 1'b0;
    else if (strobe.snoopFlush)                pushPending <= 1'b0;
    else if (strobe.snoopAccept && pushNeeded) pushPending <= 1'b1;
    else if (pushDataDone)                     pushPending <= 1'b0;
  end

  // settle window after address phase or push data phase
  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)              settleCnt <= '0;
    else if (strobe.snoopFlush) settleCnt <= '0;
    else if ((strobe.snoopAccept && !pushNeeded) || (pushDataDone && pushPending))
                                settleCnt <= SET_LOAD;
    else if (settleCnt != '0)   settleCnt <= settleCnt - 1'b1;
  end

  // wake latency counter
  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)            wakeCnt <= '0;
    else if (strobe.wakeLoad) wakeCnt <= WAKE_LD;
    else if (wakeCnt != '0)   wakeCnt <= wakeCnt - 1'b1;
  end

  always_comb begin
    status.negHit    = strobe.countNeg && !quiesceAck && (negCnt >= NEG_LAST);
    status.snoopIdle = !pushPending && (settleCnt == '0);
    status.wakeDone  = (wakeCnt == '0);
  end

endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int WAKE_W = 7
) (
  input  logic              clk,
  input  logic              rstHardN,
  input  logic              quiesceAck,
  input  logic              xferStart,
  input  logic [WAKE_W-1:0] wakeSrc,
  input  logic              napReq,
  input  logic              sleepReq,
  input  dpStatus_t         status,
  output ctlStrobe_t        strobe,
  output pwrMode_e          state,
  output logic              protoErr
);

  pwrMode_e stateNext;
  logic     protoNext;
  logic     anyWake;

  assign anyWake = |wakeSrc;

  always_comb begin
    stateNext          = state;
    protoNext          = 1'b0;
    strobe             = '0;
    strobe.countNeg    = (state == MODE_NAP) || (state == MODE_DOZE);
    unique case (state)
      MODE_FULL: begin
        if (sleepReq)    stateNext = MODE_SLEEP;
        else if (napReq) stateNext = MODE_NAP;
      end
      MODE_NAP: begin
        if (anyWake) begin
          stateNext       = MODE_WAKE;
          strobe.wakeLoad = 1'b1;
        end else begin
          protoNext = xferStart;
          if (status.negHit) stateNext = MODE_DOZE;
        end
      end
      MODE_DOZE: begin
        if (anyWake) begin
          stateNext         = MODE_WAKE;
          strobe.wakeLoad   = 1'b1;
          strobe.snoopFlush = 1'b1;
        end else begin
          strobe.snoopAccept = xferStart;
          if (quiesceAck && status.snoopIdle && !xferStart) stateNext = MODE_NAP;
        end
      end
      MODE_SLEEP: begin
        if (anyWake) begin
          stateNext       = MODE_WAKE;
          strobe.wakeLoad = 1'b1;
        end
      end
      MODE_WAKE: begin
        if (status.wakeDone) stateNext = MODE_FULL;
      end
      default: stateNext = MODE_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN) begin
      state    <= MODE_FULL;
      protoErr <= 1'b0;
    end else begin
      state    <= stateNext;
      protoErr <= protoNext;
    end
  end

endmodule

// File: rtl/snoop_power_ctrl.sv
module snoop_power_ctrl
  import spc_pkg::*;
#(
  parameter int NEG_THRESH = 4,
  parameter int SETTLE_CYC = 2,
  parameter int WAKE_LAT   = 3,
  parameter int WAKE_W     = 7
) (
  input  logic              clk,
  input  logic              rstHardN,
  input  logic              quiesceAck,
  input  logic              xferStart,
  input  logic              pushNeeded,
  input  logic              pushDataDone,
  input  logic [WAKE_W-1:0] wakeSrc,
  input  logic              napReq,
  input  logic              sleepReq,
  input  logic              pllCfgOff,
  output logic [2:0]        mode,
  output logic              snoopEn,
  output logic              pllOffReq,
  output logic              protoErr
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  pwrMode_e   state;

  spc_ctrl #(.WAKE_W(WAKE_W)) u_ctrl (
    .clk       (clk),
    .rstHardN  (rstHardN),
    .quiesceAck(quiesceAck),
    .xferStart (xferStart),
    .wakeSrc   (wakeSrc),
    .napReq    (napReq),
    .sleepReq  (sleepReq),
    .status    (status),
    .strobe    (strobe),
    .state     (state),
    .protoErr  (protoErr)
  );

  spc_dpath #(
    .NEG_THRESH(NEG_THRESH),
    .SETTLE_CYC(SETTLE_CYC),
    .WAKE_LAT  (WAKE_LAT)
  ) u_dpath (
    .clk         (clk),
    .rstHardN    (rstHardN),
    .quiesceAck  (quiesceAck),
    .pushNeeded  (pushNeeded),
    .pushDataDone(pushDataDone),
    .strobe      (strobe),
    .status      (status)
  );

  assign mode      = state;
  assign snoopEn   = (state == MODE_FULL) || (state == MODE_DOZE);
  assign pllOffReq = (state == MODE_SLEEP) && pllCfgOff;

endmodule

// File: rtl/snoop_power_ctrl_chk.sv
module snoop_power_ctrl_chk #(
  parameter int NEG_THRESH = 4,
  parameter int WAKE_W     = 7
) (
  input logic              clk,
  input logic              rstHardN,
  input logic              quiesceAck,
  input logic              xferStart,
  input logic [WAKE_W-1:0] wakeSrc,
  input logic              pllCfgOff,
  input logic [2:0]        mode,
  input logic              snoopEn,
  input logic              pllOffReq,
  input logic              protoErr
);

  localparam logic [2:0] FULL  = 3'd0;
  localparam logic [2:0] DOZE  = 3'd1;
  localparam logic [2:0] NAP   = 3'd2;
  localparam logic [2:0] SLEEP = 3'd3;
  localparam logic [2:0] WAKE  = 3'd4;
  localparam int RUN_W = $clog2(NEG_THRESH + 1);

  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN)                      lowRun <= '0;
    else if (quiesceAck)                lowRun <= '0;
    else if (lowRun != RUN_W'(NEG_THRESH)) lowRun <= lowRun + 1'b1;
  end

  AST_NO_EARLY_DOZE: assert property (@(posedge clk) disable iff (!rstHardN)
    (mode == NAP && (quiesceAck || lowRun < RUN_W'(NEG_THRESH - 1))) |=> mode != DOZE); // R3

  AST_PROTO_FROM_NAP: assert property (@(posedge clk) disable iff (!rstHardN)
    protoErr |-> ($past(mode) == NAP && $past(xferStart))); // R4

  AST_NAP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstHardN)
    ($past(mode) == DOZE && mode == NAP) |-> $past(quiesceAck)); // R5

  AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rstHardN)
    ((mode == NAP || mode == DOZE || mode == SLEEP) && (|wakeSrc)) |=> mode == WAKE); // R8

  AST_FULL_ONLY_FROM_WAKE: assert property (@(posedge clk) disable iff (!rstHardN)
    (mode == FULL && $past(mode) != FULL) |-> $past(mode) == WAKE); // R8

  AST_SNOOP_GATE: assert property (@(posedge clk) disable iff (!rstHardN)
    snoopEn |-> (mode == FULL || mode == DOZE)); // R9

  AST_PLL_OFF_SLEEP: assert property (@(posedge clk) disable iff (!rstHardN)
    pllOffReq |-> (mode == SLEEP && pllCfgOff && !snoopEn)); // R10

endmodule

bind snoop_power_ctrl snoop_power_ctrl_chk #(.NEG_THRESH(NEG_THRESH), .WAKE_W(WAKE_W)) u_chk (
  .clk       (clk),
  .rstHardN  (rstHardN),
  .quiesceAck(quiesceAck),
  .xferStart (xferStart),
  .wakeSrc   (wakeSrc),
  .pllCfgOff (pllCfgOff),
  .mode      (mode),
  .snoopEn   (snoopEn),
  .pllOffReq (pllOffReq),
  .protoErr  (protoErr)
);

// File: tb/tb_snoop_power_ctrl.sv
module tb_snoop_power_ctrl;

  localparam int CLK_P = 10;
  localparam int M_FULL = 0, M_DOZE = 1, M_NAP = 2, M_SLEEP = 3, M_WAKE = 4;

  logic       clk = 1'b0;
  logic       rstHardN = 1'b0;
  logic       quiesceAck = 1'b1;
  logic       xferStart = 1'b0;
  logic       pushNeeded = 1'b0;
  logic       pushDataDone = 1'b0;
  logic [6:0] wakeSrc = '0;
  logic       napReq = 1'b0;
  logic       sleepReq = 1'b0;
  logic       pllCfgOff = 1'b0;
  logic [2:0] mode;
  logic       snoopEn, pllOffReq, protoErr;

  int checks = 0;
  int fails  = 0;

  snoop_power_ctrl dut (
    .clk(clk), .rstHardN(rstHardN), .quiesceAck(quiesceAck), .xferStart(xferStart),
    .pushNeeded(pushNeeded), .pushDataDone(pushDataDone), .wakeSrc(wakeSrc),
    .napReq(napReq), .sleepReq(sleepReq), .pllCfgOff(pllCfgOff),
    .mode(mode), .snoopEn(snoopEn), .pllOffReq(pllOffReq), .protoErr(protoErr)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    quiesceAck = 1'b1; xferStart = 1'b0; pushNeeded = 1'b0; pushDataDone = 1'b0;
    wakeSrc = '0; napReq = 1'b0; sleepReq = 1'b0; pllCfgOff = 1'b0;
    rstHardN = 1'b0;
    tick();
    tick();
    rstHardN = 1'b1;
  endtask

  task automatic enterNap();
    napReq = 1'b1;
    tick();
    napReq = 1'b0;
  endtask

  task automatic enterDoze();
    quiesceAck = 1'b0;
    for (int i = 0; i < 4; i++) tick();
  endtask

  initial begin
    doReset();
    // R1 reset state
    chk("R1 mode", mode, M_FULL);
    chk("R1 snoopEn", snoopEn, 1);
    chk("R1 pllOffReq", pllOffReq, 0);
    chk("R1 protoErr", protoErr, 0);

    // R2 nap entry, R11 sleep request ignored in nap
    enterNap();
    chk("R2 nap entry", mode, M_NAP);
    chk("R9 nap snoopEn", snoopEn, 0);
    sleepReq = 1'b1;
    tick();
    sleepReq = 1'b0;
    chk("R11 sleepReq in nap", mode, M_NAP);

    // R3 / R7 sweep of negation run length
    for (int runLen = 1; runLen <= 6; runLen++) begin
      quiesceAck = 1'b1;
      tick();
      chk("R3 start nap", mode, M_NAP);
      quiesceAck = 1'b0;
      for (int i = 1; i <= runLen; i++) begin
        tick();
        chk("R3 run mode", mode, (i >= 4) ? M_DOZE : M_NAP);
        chk("R9 run snoopEn", snoopEn, (i >= 4) ? 1 : 0);
      end
      quiesceAck = 1'b1;
      tick();
      chk("R7 idle doze return", mode, M_NAP);
    end

    // R3 a high sample restarts the run
    quiesceAck = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    quiesceAck = 1'b1;
    tick();
    quiesceAck = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    chk("R3 run restarted", mode, M_NAP);
    tick();
    chk("R3 fourth low after restart", mode, M_DOZE);
    quiesceAck = 1'b1;
    tick();
    chk("R7 back to nap", mode, M_NAP);

    // R4 transfer start while napping
    xferStart = 1'b1;
    tick();
    xferStart = 1'b0;
    chk("R4 protoErr set", protoErr, 1);
    chk("R4 mode stays nap", mode, M_NAP);
    tick();
    chk("R4 protoErr pulse ends", protoErr, 0);
    enterDoze();
    chk("R4 doze reached", mode, M_DOZE);
    quiesceAck = 1'b1;
    tick();
    chk("R4 no snoop pending", mode, M_NAP);

    // R5 no-push snoop, acknowledge reasserted after k edges
    for (int k = 1; k <= 4; k++) begin
      enterDoze();
      xferStart = 1'b1; pushNeeded = 1'b0;
      tick();
      xferStart = 1'b0;
      chk("R5 snoop accepted", mode, M_DOZE);
      for (int j = 1; j <= 6; j++) begin
        quiesceAck = (j >= k);
        tick();
        chk("R5 settle", mode, (j >= ((k > 3) ? k : 3)) ? M_NAP : M_DOZE);
      end
      quiesceAck = 1'b1;
    end

    // R6 snoop with push, data phase ending after d edges
    for (int d = 1; d <= 4; d++) begin
      enterDoze();
      xferStart = 1'b1; pushNeeded = 1'b1;
      tick();
      xferStart = 1'b0; pushNeeded = 1'b0;
      quiesceAck = 1'b1;
      for (int j = 1; j <= d + 5; j++) begin
        pushDataDone = (j == d);
        tick();
        chk("R6 push hold", mode, (j >= d + 3) ? M_NAP : M_DOZE);
      end
      pushDataDone = 1'b0;
    end

    // R8 wake from every low-power mode through every source bit
    for (int from = 0; from < 3; from++) begin
      for (int b = 0; b < 7; b++) begin
        doReset();
        if (from == 0) enterNap();
        else if (from == 1) begin enterNap(); enterDoze(); end
        else begin sleepReq = 1'b1; tick(); sleepReq = 1'b0; end
        chk("R8 source mode", mode, (from == 0) ? M_NAP : (from == 1) ? M_DOZE : M_SLEEP);
        wakeSrc = 7'(1 << b);
        tick();
        wakeSrc = '0;
        quiesceAck = 1'b1;
        chk("R8 waking", mode, M_WAKE);
        chk("R9 waking snoopEn", snoopEn, 0);
        tick();
        chk("R8 waking 2", mode, M_WAKE);
        tick();
        chk("R8 waking 3", mode, M_WAKE);
        tick();
        chk("R8 full", mode, M_FULL);
        chk("R9 full snoopEn", snoopEn, 1);
      end
    end

    // R10 sleep with both clock configurations, R2 sleep priority, R11 snoop in sleep
    for (int cfg = 0; cfg < 2; cfg++) begin
      doReset();
      pllCfgOff = cfg[0];
      tick();
      chk("R10 no request in full", pllOffReq, 0);
      sleepReq = 1'b1; napReq = 1'b1;
      tick();
      sleepReq = 1'b0; napReq = 1'b0;
      chk("R2 sleep wins", mode, M_SLEEP);
      chk("R10 pllOffReq", pllOffReq, cfg);
      chk("R9 sleep snoopEn", snoopEn, 0);
      xferStart = 1'b1;
      tick();
      xferStart = 1'b0;
      chk("R11 xfer in sleep mode", mode, M_SLEEP);
      chk("R11 xfer in sleep protoErr", protoErr, 0);
    end

    // R11 wake sources ignored in full
    doReset();
    wakeSrc = 7'h7f;
    tick();
    tick();
    wakeSrc = '0;
    chk("R11 wake in full", mode, M_FULL);

    // R1 asynchronous hard reset between edges
    enterNap();
    chk("R1 pre-reset nap", mode, M_NAP);
    rstHardN = 1'b0;
    #2;
    chk("R1 async mode", mode, M_FULL);
    chk("R1 async snoopEn", snoopEn, 1);
    tick();
    rstHardN = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule